// File: doc/BRIEF.md
# Blocking Neighbor Port Unit with Pin Wake

This block is the communication port unit of one core in a small multicore stack processor. The core reaches up to four neighbor directions through it. A read names one or more directions as a bit mask and holds a request. The block keeps the core stalled until one of the selected sources is ready. It then returns that source's word and ends the read with a one-cycle done pulse. A neighbor offers a word by raising its write strobe and holding its data. The neighbor keeps both until it sees a one-cycle acknowledge from this block.

A direction that has no neighbor attached takes its wake from a single external pin. A synchronized edge of the configured polarity is latched as a pin event. The pin event plays the part of a neighbor's write handshake. A read served by the pin event always returns one fixed instruction word, "fetch status through B, then return", and never undefined data. The core uses the same read request for an instruction fetch through the program counter and for a data read through an address register. Both kinds of access therefore receive the same word. A status output shows the per-direction pending writes, the synchronized pin level and the latched pin event. Software reads it to tell a pin wake from incoming neighbor data.

Top module: `comm_port_unit`

## Requirements
- R1: After reset, stall_o, rd_done_o and nbr_ack_o are 0, and status_o is 0 while the pin is low.
- R2: While rd_req_i is high and no selected source is ready, stall_o stays 1 and rd_done_o stays 0. stall_o is 1 only while rd_req_i is high.
- R3: When a selected neighbor direction d holds nbr_wr_i[d] high during an eligible read, the next cycle shows the following: rd_done_o=1, stall_o=0, rd_data_o equal to that neighbor's word, and nbr_ack_o equal to the one-hot bit of d. Direction d's word sits at bits [d*DATA_W +: DATA_W] of nbr_data_i.
- R4: nbr_ack_o is at most one-hot and lasts exactly one cycle per transfer. A writer that keeps nbr_wr_i high after its acknowledge, with no new read, gets no further acknowledge.
- R5: When several selected neighbors are ready at once, the lowest-index direction is served. Writers on unselected directions are not acknowledged.
- R6: On a neighborless direction (HAS_NBR bit 0; default HAS_NBR=4'b1110, so direction 0 has no neighbor), nbr_wr_i is ignored. It never completes a read and never produces an acknowledge.
- R7: With PIN_RISE=1, a rising pin edge wakes a read that selects a neighborless direction. rd_done_o rises four clock edges after the pin changes, with rd_data_o = WAKE_WORD (default 18'h05A3F). A falling edge does not wake the read.
- R8: If a neighbor and the latched pin event are both ready for one read, the neighbor is served. The pin event stays latched and serves the next read of the neighborless direction.
- R9: status_o[NUM_DIR-1:0] shows a neighbor write that is waiting, one cycle after the strobe rises. A bit clears in the cycle its read completes. status_o[NUM_DIR] is the synchronized pin level, and status_o[NUM_DIR+1] is the latched pin event.
- R10: A pin event that arrives with no read waiting is held. A later read that selects a neighborless direction completes one cycle after the request, with WAKE_WORD, and clears the event.
- R11: rd_done_o is a one-cycle pulse, even if rd_req_i stays high into the done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_req_i | input | 1 | Core read request, held until done |
| rd_sel_i | input | NUM_DIR | Direction mask of the port address |
| rd_data_o | output | DATA_W | Word delivered with done |
| rd_done_o | output | 1 | One-cycle read completion |
| stall_o | output | 1 | Core must wait |
| nbr_wr_i | input | NUM_DIR | Neighbor write strobes, held until ack |
| nbr_data_i | input | NUM_DIR*DATA_W | Neighbor words, direction d at [d*DATA_W +: DATA_W] |
| nbr_ack_o | output | NUM_DIR | One-cycle acknowledge per direction |
| pin_i | input | 1 | Asynchronous wake pin |
| status_o | output | NUM_DIR+2 | {pin event, pin level, pending[NUM_DIR-1:0]} |

## Verification
A lost or stuck pin event shows up at the ports in one of two ways. Either the read that selects the neighborless port stays stalled past the fixed four-edge wake latency, or it completes one cycle after the request with no new edge on the pin. The status event bit also disagrees within a cycle. A wrong priority or a stale acknowledge mask appears in the first cycle after a grant. The symptom is a word from the wrong direction, an acknowledge on an unselected or neighborless direction, or a second acknowledge to a writer that is still holding its strobe. Pending bits that fail to clear are visible on status_o one cycle after the transfer.

// File: rtl/comm_port_pkg.sv
package comm_port_pkg;
  // "fetch via B, return" encoding delivered by the neighborless port
  localparam logic [17:0] WAKE_WORD_DEF = 18'h05A3F;
endpackage

// File: rtl/cpu_pin_wake.sv
module cpu_pin_wake #(
  parameter bit PIN_RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic take_i,
  output logic lvl_o,
  output logic evt_o
);
  logic s1_q, s2_q, s3_q, evt_q, edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  generate
    if (PIN_RISE) begin : g_rise
      assign edge_hit = s2_q & ~s3_q;
    end else begin : g_fall
      assign edge_hit = ~s2_q & s3_q;
    end
  endgenerate

  // a fresh edge wins over a same-cycle consume
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= edge_hit | (evt_q & ~take_i);
  end

  assign lvl_o = s2_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/cpu_port_arb.sv
module cpu_port_arb #(
  parameter int NUM_DIR = 4,
  parameter logic [NUM_DIR-1:0] HAS_NBR = 4'b1110
) (
  input  logic               req_i,
  input  logic [NUM_DIR-1:0] sel_i,
  input  logic [NUM_DIR-1:0] wr_i,
  input  logic [NUM_DIR-1:0] ack_i,
  input  logic               evt_i,
  output logic [NUM_DIR-1:0] nbr_gnt_o,
  output logic               pin_gnt_o
);
  logic [NUM_DIR-1:0] nbr_rdy;

  // ack_i masks a writer still holding its strobe in the ack cycle
  assign nbr_rdy   = HAS_NBR & wr_i & sel_i & ~ack_i & {NUM_DIR{req_i}};
  assign nbr_gnt_o = nbr_rdy & (~nbr_rdy + 1'b1);
  assign pin_gnt_o = req_i & evt_i & ~(|nbr_rdy) & (|(sel_i & ~HAS_NBR));
endmodule

// File: rtl/cpu_pend_track.sv
module cpu_pend_track #(
  parameter int NUM_DIR = 4,
  parameter logic [NUM_DIR-1:0] HAS_NBR = 4'b1110
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DIR-1:0] wr_i,
  input  logic [NUM_DIR-1:0] gnt_i,
  input  logic [NUM_DIR-1:0] ack_i,
  output logic [NUM_DIR-1:0] pend_o
);
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    if (HAS_NBR[d]) begin : g_live
      logic p_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= 1'b0;
        else         p_q <= wr_i[d] & ~gnt_i[d] & ~ack_i[d];
      end
      assign pend_o[d] = p_q;
    end else begin : g_none
      assign pend_o[d] = 1'b0;
    end
  end
endmodule

// File: rtl/comm_port_unit.sv
module comm_port_unit
  import comm_port_pkg::*;
#(
  parameter int NUM_DIR = 4,
  parameter int DATA_W  = 18,
  parameter logic [NUM_DIR-1:0] HAS_NBR = 4'b1110,
  parameter logic [DATA_W-1:0]  WAKE_WORD = WAKE_WORD_DEF,
  parameter bit PIN_RISE = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_req_i,
  input  logic [NUM_DIR-1:0]        rd_sel_i,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic                      rd_done_o,
  output logic                      stall_o,
  input  logic [NUM_DIR-1:0]        nbr_wr_i,
  input  logic [NUM_DIR*DATA_W-1:0] nbr_data_i,
  output logic [NUM_DIR-1:0]        nbr_ack_o,
  input  logic                      pin_i,
  output logic [NUM_DIR+1:0]        status_o
);
  logic               done_q, eligible, pin_gnt, pin_lvl, pin_evt;
  logic [NUM_DIR-1:0] ack_q, nbr_gnt, pend;
  logic [DATA_W-1:0]  data_q, data_sel;

  assign eligible = rd_req_i & ~done_q;

  cpu_pin_wake #(.PIN_RISE(PIN_RISE)) u_pin (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .take_i(pin_gnt), .lvl_o(pin_lvl), .evt_o(pin_evt)
  );

  cpu_port_arb #(.NUM_DIR(NUM_DIR), .HAS_NBR(HAS_NBR)) u_arb (
    .req_i(eligible), .sel_i(rd_sel_i), .wr_i(nbr_wr_i), .ack_i(ack_q),
    .evt_i(pin_evt), .nbr_gnt_o(nbr_gnt), .pin_gnt_o(pin_gnt)
  );

  cpu_pend_track #(.NUM_DIR(NUM_DIR), .HAS_NBR(HAS_NBR)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(nbr_wr_i),
    .gnt_i(nbr_gnt), .ack_i(ack_q), .pend_o(pend)
  );

  always_comb begin
    data_sel = WAKE_WORD;
    for (int d = 0; d < NUM_DIR; d++) begin
      if (nbr_gnt[d]) data_sel = nbr_data_i[d*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ack_q  <= '0;
      data_q <= '0;
    end else begin
      done_q <= (|nbr_gnt) | pin_gnt;
      ack_q  <= nbr_gnt;
      if ((|nbr_gnt) | pin_gnt) data_q <= data_sel;
    end
  end

  assign rd_data_o = data_q;
  assign rd_done_o = done_q;
  assign stall_o   = eligible;
  assign nbr_ack_o = ack_q;
  assign status_o  = {pin_evt, pin_lvl, pend};
endmodule

// File: rtl/comm_port_unit_chk.sv
module comm_port_unit_chk #(
  parameter int NUM_DIR = 4,
  parameter logic [NUM_DIR-1:0] HAS_NBR = 4'b1110
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rd_req_i,
  input logic               stall_o,
  input logic               rd_done_o,
  input logic [NUM_DIR-1:0] nbr_ack_o
);
  assert_stall_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> rd_req_i);
  assert_done_after_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> $past(rd_req_i));
  assert_ack_with_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|nbr_ack_o) |-> rd_done_o);
  assert_ack_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(nbr_ack_o));
  assert_ack_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|nbr_ack_o) |=> ((nbr_ack_o & $past(nbr_ack_o)) == '0));
  assert_no_ack_missing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nbr_ack_o & ~HAS_NBR) == '0);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o);
endmodule

bind comm_port_unit comm_port_unit_chk #(.NUM_DIR(NUM_DIR), .HAS_NBR(HAS_NBR)) chk_i (.*);

// File: tb/comm_port_unit_tb.sv
module comm_port_unit_tb_top;
  localparam int ND = 4;
  localparam int DW = 18;
  localparam logic [ND-1:0] HAS = 4'b1110;
  localparam logic [DW-1:0] WAKE = 18'h05A3F;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rd_req_i = 1'b0, pin_i = 1'b0;
  logic [ND-1:0] rd_sel_i = '0, nbr_wr_i = '0;
  logic [ND*DW-1:0] nbr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic rd_done_o, stall_o;
  logic [ND-1:0] nbr_ack_o;
  logic [ND+1:0] status_o;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  comm_port_unit dut_i (.clk_i(clk), .*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int low_dir(input logic [ND-1:0] m);
    for (int d = 0; d < ND; d++) if (m[d]) return d;
    return -1;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] w [ND];
    logic [ND-1:0] wm, sm;
    int e;
    void'($urandom(32'd4711));
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk(status_o == '0, "R1 status", status_o, 0);
    chk(!stall_o && !rd_done_o && nbr_ack_o == '0, "R1 outputs", {stall_o, rd_done_o, nbr_ack_o}, 0);

    // R2: nothing ready
    rd_req_i = 1'b1; rd_sel_i = 4'b0110;
    repeat (4) tick();
    chk(stall_o && !rd_done_o, "R2 stalled", {stall_o, rd_done_o}, 2'b10);
    // R3: neighbor 2 writes
    nbr_data_i[2*DW +: DW] = 18'h2ABCD; nbr_wr_i = 4'b0100;
    tick();
    chk(rd_done_o && !stall_o, "R3 done", {rd_done_o, stall_o}, 2'b10);
    chk(rd_data_o == 18'h2ABCD, "R3 data", rd_data_o, 18'h2ABCD);
    chk(nbr_ack_o == 4'b0100, "R3 ack", nbr_ack_o, 4'b0100);
    rd_req_i = 1'b0;  // writer keeps strobe high
    tick();
    chk(!rd_done_o, "R11 done pulse", rd_done_o, 0);
    repeat (3) begin
      chk(nbr_ack_o == '0, "R4 no second ack", nbr_ack_o, 0);
      tick();
    end
    chk(status_o[2] == 1'b1, "R9 pending set", status_o, 4);
    // R9: read clears pending
    rd_req_i = 1'b1; rd_sel_i = 4'b0100; nbr_data_i[2*DW +: DW] = 18'h01111;
    tick();
    chk(rd_done_o && rd_data_o == 18'h01111, "R9 read pending word", rd_data_o, 18'h01111);
    chk(status_o[3:0] == 4'b0000, "R9 pending cleared", status_o, 0);
    rd_req_i = 1'b0; nbr_wr_i = '0;
    tick();

    // R11: request held into done cycle
    rd_req_i = 1'b1; rd_sel_i = 4'b0010; nbr_wr_i = 4'b0010; nbr_data_i[DW +: DW] = 18'h00777;
    tick();
    chk(rd_done_o, "R11 done", rd_done_o, 1);
    nbr_wr_i = '0;
    tick();
    chk(!rd_done_o && stall_o, "R11 single pulse", {rd_done_o, stall_o}, 2'b01);
    rd_req_i = 1'b0;
    tick();

    // R5: priority and unselected writer
    nbr_data_i[DW +: DW] = 18'h11111; nbr_data_i[2*DW +: DW] = 18'h22222; nbr_data_i[3*DW +: DW] = 18'h33333;
    nbr_wr_i = 4'b1110; rd_sel_i = 4'b1100; rd_req_i = 1'b1;
    tick();
    chk(rd_data_o == 18'h22222 && nbr_ack_o == 4'b0100, "R5 lowest selected", rd_data_o, 18'h22222);
    rd_req_i = 1'b0; nbr_wr_i = '0;
    tick();
    chk(nbr_ack_o == '0 && status_o[3:0] == '0, "R5 unselected no ack", {nbr_ack_o, status_o[3:0]}, 0);

    // R6: write strobe on neighborless direction ignored
    nbr_wr_i = 4'b0001; nbr_data_i[DW-1:0] = 18'h3FFFF; rd_sel_i = 4'b0001; rd_req_i = 1'b1;
    repeat (5) begin
      tick();
      chk(stall_o && !rd_done_o && nbr_ack_o == '0, "R6 ignored", {stall_o, rd_done_o, nbr_ack_o}, 6'h20);
    end
    chk(status_o[3:0] == '0, "R6 no pending", status_o, 0);
    nbr_wr_i = '0;

    // R7: rising edge wakes after four edges
    pin_i = 1'b1;
    tick();
    chk(!rd_done_o, "R7 edge1", rd_done_o, 0);
    tick();
    chk(!rd_done_o && status_o[4], "R7 edge2 level", status_o, 6'h10);
    tick();
    chk(!rd_done_o && stall_o && status_o[5], "R7 edge3 event", status_o, 6'h30);
    tick();
    chk(rd_done_o && !stall_o, "R7 edge4 done", rd_done_o, 1);
    chk(rd_data_o == WAKE, "R7 wake word", rd_data_o, WAKE);
    chk(!status_o[5], "R7 event consumed", status_o, 6'h10);
    rd_req_i = 1'b0;
    tick();
    // falling edge does not wake
    rd_req_i = 1'b1; pin_i = 1'b0;
    repeat (6) tick();
    chk(stall_o && !rd_done_o && status_o == '0, "R7 falling no wake", status_o, 0);
    rd_req_i = 1'b0;
    tick();

    // R10: latched event serves a later read
    pin_i = 1'b1;
    repeat (6) tick();
    chk(status_o[5], "R10 event held", status_o, 6'h30);
    rd_req_i = 1'b1; rd_sel_i = 4'b0001;
    tick();
    chk(rd_done_o && rd_data_o == WAKE, "R10 prompt wake", rd_data_o, WAKE);
    chk(!status_o[5], "R10 event cleared", status_o, 6'h10);
    rd_req_i = 1'b0;
    tick();

    // R8: neighbor beats latched pin event
    pin_i = 1'b0;
    repeat (3) tick();
    pin_i = 1'b1;
    repeat (5) tick();
    rd_sel_i = 4'b0011; rd_req_i = 1'b1; nbr_wr_i = 4'b0010; nbr_data_i[DW +: DW] = 18'h0ABCD;
    tick();
    chk(rd_data_o == 18'h0ABCD && nbr_ack_o == 4'b0010, "R8 neighbor first", rd_data_o, 18'h0ABCD);
    chk(status_o[5], "R8 event kept", status_o, 6'h30);
    rd_req_i = 1'b0; nbr_wr_i = '0;
    tick();
    rd_req_i = 1'b1; rd_sel_i = 4'b0001;
    tick();
    chk(rd_done_o && rd_data_o == WAKE, "R8 pin next", rd_data_o, WAKE);
    rd_req_i = 1'b0; pin_i = 1'b0;
    repeat (4) tick();

    // random multiport reads
    for (int it = 0; it < 60; it++) begin
      wm = 4'($urandom) & HAS;
      if (wm == '0) wm = 4'b0010 << ($urandom % 3);
      sm = 4'($urandom);
      if ((sm & wm) == '0) sm = sm | wm;
      for (int d = 0; d < ND; d++) begin
        w[d] = DW'($urandom);
        nbr_data_i[d*DW +: DW] = w[d];
      end
      e = low_dir(sm & wm & HAS);
      nbr_wr_i = wm; rd_sel_i = sm; rd_req_i = 1'b1;
      tick();
      chk(rd_done_o && rd_data_o == w[e], "R5 random word", rd_data_o, w[e]);
      chk(nbr_ack_o == 4'(1 << e), "R3 random ack", nbr_ack_o, 1 << e);
      rd_req_i = 1'b0; nbr_wr_i = '0;
      tick();
      chk(!rd_done_o && nbr_ack_o == '0 && status_o == 6'h00, "R4 random idle", status_o, 0);
    end
    finish_run();
  end
endmodule